// File: doc/BRIEF.md
# Fat-Tree Source Route Generator

This block sits in a processor's network interface and turns a pair of leaf addresses into the list of hop commands that a message header carries through a fat-tree network. Every switch in the tree has four child ports and two parent ports. Processors hang off the leaves. A leaf address is read as a base-4 number with one 2-bit digit per tree level, and digit 0 selects the child port at the switch the processor is attached to.

To get from one leaf to another, the header climbs until it reaches a switch that both leaves share. Each climbing step is an adaptive UP command, which lets the switch pick either parent. From that shared switch the header follows the only downward path to the destination, one explicit child index per level. The generator locates the highest base-4 digit in which the two addresses differ, with only the levels below the configured tree depth taken into account. It emits one UP per level above the attachment switch, then the destination's digits from that level down to digit 0. Hops leave one per cycle over a valid/ready handshake. For example, leaves that first differ in digit 2 and a destination with digits 2..0 equal to 1, 0, 3 give the sequence UP, UP, 1, 0, 3.

Top module: `fattree_route_gen`

## Requirements
- R1: After a synchronous reset, hop_valid and route_done are 0 and req_ready is 1.
- R2: For an accepted request whose highest differing digit (below the depth) is at index p, the route starts with exactly p hops carrying the code 6 (UP).
- R3: After the UP hops come p+1 child hops whose codes are the destination digits p, p-1, ..., 0 (digit i is address bits 2i+1:2i, value 0..3), most significant first.
- R4: Digits at index depth or above play no part in the route. A depth larger than the number of levels acts as the full number of levels, and depth 0 always gives an empty route.
- R5: When no digit below the depth differs, no hop is emitted and route_done is 1 in the cycle after acceptance.
- R6: While hop_valid is 1 and hop_ready is 0, hop_valid stays 1 and hop_code and hop_last keep their values.
- R7: req_ready is 0 while a route is being emitted, and a request presented then has no effect on the hops.
- R8: hop_last is 1 exactly on the final hop. In the cycle after that hop is taken, route_done is 1 and hop_valid is 0.
- R9: Once a child hop has been taken, no UP hop follows in the same route.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Generator idle, request accepted on this edge |
| req_src | input | 2*LVL | Source leaf address |
| req_dst | input | 2*LVL | Destination leaf address |
| req_depth | input | DEPTH_W | Number of tree levels in use |
| hop_valid | output | 1 | Hop command available |
| hop_ready | input | 1 | Downstream takes the hop |
| hop_code | output | 4 | Hop command: 0..3 child index, 6 UP |
| hop_last | output | 1 | Final hop of the route |
| route_done | output | 1 | One-cycle pulse when a route has finished |

## Verification
The hardest case to reach is a request that arrives while a stalled route is still in flight, combined with backpressure on the final hop. That is where a late drop of busy, or a state change during a stall, would corrupt the sequence. The stimulus holds req_valid high with fresh random addresses for the whole length of every route and drives hop_ready at random. This places stalls on UP hops, on child hops and on the last hop. Directed cases cover the worked five-hop example, the longest route, depth masking and depth clamping, and the empty route.

// File: rtl/route_pkg.sv
package route_pkg;
  localparam int HOP_W = 4;
  typedef logic [HOP_W-1:0] hop_t;
  localparam hop_t HOP_UP = hop_t'(6);
endpackage

// File: rtl/route_lca.sv
module route_lca #(
  parameter int LVL     = 4,
  parameter int DEPTH_W = $clog2(LVL + 1),
  parameter int CNT_W   = (LVL > 1) ? $clog2(LVL) : 1
) (
  input  logic [2*LVL-1:0] src,
  input  logic [2*LVL-1:0] dst,
  input  logic [DEPTH_W-1:0] depth,
  output logic             differ,
  output logic [CNT_W-1:0] top
);
  logic [LVL-1:0] diff;

  genvar g;
  generate
    for (g = 0; g < LVL; g++) begin : g_digit
      assign diff[g] = (32'(depth) > g) && (src[2*g +: 2] != dst[2*g +: 2]);
    end
  endgenerate

  always_comb begin
    top = '0;
    for (int i = 0; i < LVL; i++) begin
      if (diff[i]) top = CNT_W'(i);
    end
  end

  assign differ = |diff;
endmodule

// File: rtl/route_seq.sv
module route_seq
  import route_pkg::*;
#(
  parameter int LVL   = 4,
  parameter int CNT_W = (LVL > 1) ? $clog2(LVL) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             differ,
  input  logic [CNT_W-1:0] top,
  input  logic [2*LVL-1:0] dst,
  input  logic             hop_ready,
  output logic             busy,
  output logic             hop_valid,
  output hop_t             hop_code,
  output logic             hop_last,
  output logic             route_done
);
  logic [CNT_W-1:0] ups_left;
  logic [CNT_W-1:0] dig_idx;
  logic [2*LVL-1:0] dst_q;
  logic             take;

  assign take = busy && hop_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy       <= 1'b0;
      ups_left   <= '0;
      dig_idx    <= '0;
      dst_q      <= '0;
      route_done <= 1'b0;
    end else begin
      route_done <= 1'b0;
      if (!busy) begin
        if (start) begin
          if (differ) begin
            busy     <= 1'b1;
            ups_left <= top;
            dig_idx  <= top;
            dst_q    <= dst;
          end else begin
            route_done <= 1'b1;
          end
        end
      end else if (take) begin
        if (ups_left != '0) begin
          ups_left <= ups_left - 1'b1;
        end else if (dig_idx == '0) begin
          busy       <= 1'b0;
          route_done <= 1'b1;
        end else begin
          dig_idx <= dig_idx - 1'b1;
        end
      end
    end
  end

  assign hop_valid = busy;
  assign hop_code  = (ups_left != '0) ? HOP_UP : hop_t'(dst_q[2*dig_idx +: 2]);
  assign hop_last  = busy && (ups_left == '0) && (dig_idx == '0);
endmodule

// File: rtl/fattree_route_gen.sv
module fattree_route_gen
  import route_pkg::*;
#(
  parameter int LVL     = 4,
  parameter int DEPTH_W = $clog2(LVL + 1),
  localparam int ADDR_W = 2 * LVL,
  localparam int CNT_W  = (LVL > 1) ? $clog2(LVL) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [ADDR_W-1:0]  req_src,
  input  logic [ADDR_W-1:0]  req_dst,
  input  logic [DEPTH_W-1:0] req_depth,
  output logic               hop_valid,
  input  logic               hop_ready,
  output logic [HOP_W-1:0]   hop_code,
  output logic               hop_last,
  output logic               route_done
);
  logic             busy;
  logic             differ;
  logic [CNT_W-1:0] top;
  logic             start;

  assign req_ready = !busy;
  assign start     = req_valid && req_ready;

  route_lca #(.LVL(LVL), .DEPTH_W(DEPTH_W), .CNT_W(CNT_W)) u_lca (
    .src(req_src), .dst(req_dst), .depth(req_depth),
    .differ(differ), .top(top)
  );

  route_seq #(.LVL(LVL), .CNT_W(CNT_W)) u_seq (
    .clk(clk), .rst(rst), .start(start), .differ(differ), .top(top),
    .dst(req_dst), .hop_ready(hop_ready), .busy(busy),
    .hop_valid(hop_valid), .hop_code(hop_code), .hop_last(hop_last),
    .route_done(route_done)
  );
endmodule

// File: rtl/route_gen_chk.sv
module route_gen_chk #(
  parameter int LVL = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             req_valid,
  input logic             req_ready,
  input logic [2*LVL-1:0] req_src,
  input logic [2*LVL-1:0] req_dst,
  input logic             hop_valid,
  input logic             hop_ready,
  input logic [3:0]       hop_code,
  input logic             hop_last,
  input logic             route_done
);
  // R1
  reset_idle_chk: assert property (@(posedge clk)
    rst |=> (!hop_valid && !route_done && req_ready));

  // R5
  empty_route_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && req_src == req_dst) |=> (route_done && !hop_valid));

  // R6
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (hop_valid && !hop_ready) |=> (hop_valid && $stable(hop_code) && $stable(hop_last)));

  // R7
  busy_block_chk: assert property (@(posedge clk) disable iff (rst)
    !(hop_valid && req_ready));

  // R8
  last_done_chk: assert property (@(posedge clk) disable iff (rst)
    (hop_valid && hop_ready && hop_last) |=> (route_done && !hop_valid));

  // R9
  no_up_after_child_chk: assert property (@(posedge clk) disable iff (rst)
    (hop_valid && hop_ready && hop_code != 4'd6 && !hop_last) |=> (hop_valid && hop_code != 4'd6));
endmodule

bind fattree_route_gen route_gen_chk #(.LVL(LVL)) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
  .req_src(req_src), .req_dst(req_dst), .hop_valid(hop_valid),
  .hop_ready(hop_ready), .hop_code(hop_code), .hop_last(hop_last),
  .route_done(route_done)
);

// File: tb/test_fattree_route_gen.sv
module test_fattree_route_gen;
  localparam int LVL = 4;
  localparam int AW  = 2 * LVL;
  localparam int DW  = 3;
  localparam int MAXH = 2 * LVL;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [AW-1:0] req_src = '0;
  logic [AW-1:0] req_dst = '0;
  logic [DW-1:0] req_depth = '0;
  logic hop_valid;
  logic hop_ready = 1'b0;
  logic [3:0] hop_code;
  logic hop_last;
  logic route_done;

  int n_chk = 0;
  int n_fail = 0;
  int seed_dummy;

  always #4 clk = ~clk;

  fattree_route_gen #(.LVL(LVL), .DEPTH_W(DW)) i_fattree_route_gen (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_src(req_src), .req_dst(req_dst), .req_depth(req_depth),
    .hop_valid(hop_valid), .hop_ready(hop_ready), .hop_code(hop_code),
    .hop_last(hop_last), .route_done(route_done)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // expected route from the requirements (R2, R3, R4)
  function automatic int ref_route(input logic [AW-1:0] s, input logic [AW-1:0] d,
                                   input int depth, output int hops [MAXH]);
    int p = -1;
    int n = 0;
    int lim = (depth > LVL) ? LVL : depth;
    for (int i = 0; i < lim; i++)
      if (s[2*i +: 2] != d[2*i +: 2]) p = i;
    for (int i = 0; i < MAXH; i++) hops[i] = 0;
    if (p < 0) return 0;
    for (int i = 0; i < p; i++) hops[n++] = 6;
    for (int i = p; i >= 0; i--) hops[n++] = int'(d[2*i +: 2]);
    return n;
  endfunction

  task automatic run_route(input logic [AW-1:0] s, input logic [AW-1:0] d,
                           input int depth, input int ready_pct);
    int exp_h [MAXH];
    int n_exp;
    int got = 0;
    bit stalled = 0;
    int st_code = 0;
    int st_last = 0;
    bit seq_ok = 1;
    bit done_seen;
    n_exp = ref_route(s, d, depth, exp_h);
    @(negedge clk);
    chk(req_ready == 1'b1, "R7 idle ready", int'(req_ready), 1);
    req_valid = 1'b1; req_src = s; req_dst = d; req_depth = DW'(depth);
    @(posedge clk);
    #1;
    // R7: keep presenting other requests while busy
    req_src = AW'($urandom); req_dst = AW'($urandom); req_depth = DW'($urandom);
    if (n_exp == 0) begin
      req_valid = 1'b0;
      @(negedge clk);
      chk(route_done == 1'b1 && hop_valid == 1'b0, "R5 empty route done", int'(route_done), 1);
      return;
    end
    forever begin
      @(negedge clk);
      if (stalled) begin
        chk(hop_valid && int'(hop_code) == st_code && int'(hop_last) == st_last,
            "R6 stall hold", int'(hop_code), st_code);
      end
      chk(!(hop_valid && req_ready), "R7 ready low while busy", int'(req_ready), 0);
      if (!hop_valid) begin
        chk(0, "R8 hop_valid dropped early", got, n_exp);
        req_valid = 1'b0;
        return;
      end
      hop_ready = (($urandom % 100) < ready_pct);
      if (got < MAXH && int'(hop_code) != exp_h[got]) begin
        seq_ok = 0;
        chk(0, (got < n_exp - (n_exp + 1) / 2) ? "R2 up hop" : "R3 child hop",
            int'(hop_code), exp_h[got]);
      end
      if (hop_ready) begin
        chk(hop_last == (got == n_exp - 1), "R8 last flag", int'(hop_last), int'(got == n_exp - 1));
        got++;
        stalled = 0;
        if (hop_last || got >= MAXH) begin
          @(posedge clk);
          #1 hop_ready = 1'b0;
          req_valid = 1'b0;
          @(negedge clk);
          done_seen = route_done;
          chk(done_seen && !hop_valid, "R8 done after last", int'(done_seen), 1);
          chk(got == n_exp && seq_ok, "R2 R3 R4 route length", got, n_exp);
          return;
        end
      end else begin
        stalled = 1; st_code = int'(hop_code); st_last = int'(hop_last);
      end
    end
  endtask

  initial begin
    seed_dummy = $urandom(32'h5eed_1234);
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    chk(!hop_valid && !route_done && req_ready, "R1 reset state", int'(hop_valid), 0);

    run_route(8'h23, 8'h13, 4, 100);  // R2 R3 worked example: 6,6,1,0,3
    run_route(8'h00, 8'hFF, 4, 50);   // longest route
    run_route(8'hC0, 8'h00, 3, 100);  // R4 top digit masked -> empty
    run_route(8'h12, 8'h3D, 0, 100);  // R4 depth 0 -> empty
    run_route(8'h00, 8'hC0, 7, 100);  // R4 depth clamp
    run_route(8'h5A, 8'h5A, 4, 100);  // R5 equal
    run_route(8'h41, 8'h42, 4, 30);   // one child hop only
    run_route(8'h00, 8'h3F, 2, 40);   // R4 partial depth

    for (int k = 0; k < 400; k++) begin
      logic [AW-1:0] s = AW'($urandom);
      logic [AW-1:0] d = s;
      int r = $urandom % 4;
      if (r == 0) d = AW'($urandom);
      else if (r != 1) d[2*($urandom % LVL) +: 2] = 2'($urandom);
      run_route(s, d, $urandom % 6, 20 + ($urandom % 81));
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule